// File: doc/BRIEF.md
# TMDS-Style Lane Symbol Encoder

This block encodes one video colour component per clock into a ten-bit line symbol for one serial lane. While pixels are active it works in two steps. First it chains each data bit onto the bit before it with XOR or XNOR, whichever leaves fewer transitions in the word. Then it may complement the eight chained bits so that the running balance of ones and zeros on the line stays close to zero.

While the picture is blanked, the data value is not used. The encoder instead emits one of four fixed, transition-rich symbols picked by two control inputs. These symbols let a receiver lock onto symbol boundaries. Each symbol leaves a register one clock after its inputs are sampled. Serialization and the electrical layer are outside the block.

Top module: `tmds_lane_encoder`

## Requirements
- R1: While reset (`rst_ni` low) is asserted, `sym_o` is the blanking symbol for control 00 (1101010100) and the running balance is zero. After reset, each symbol appears exactly one clock after its inputs are sampled, and `sym_o` holds its value until the next rising edge.
- R2: In an active symbol, bit 0 of the recovered word (`sym_o[7:0]`, complemented when `sym_o[9]` is 1) equals input bit 0.
- R3: Each recovered bit i from 1 to 7 is the XOR of data bit i and recovered bit i-1 when `sym_o[8]` is 1. It is the XNOR of those two bits when `sym_o[8]` is 0.
- R4: `sym_o[8]` is 0 (XNOR chaining) when the data byte has more than four ones, or exactly four ones with bit 0 clear. In every other case it is 1.
- R5: When the running balance is zero or the chained word has four ones, `sym_o[9]` is the complement of `sym_o[8]`. `sym_o[9]` = 1 always means that bits 7..0 were sent complemented.
- R6: In every other case `sym_o[9]` is 1 exactly when the chained word's excess of ones over zeros has the same sign as the running balance.
- R7: The running balance equals the sum of (ones − zeros) over the ten bits of every active symbol sent since the last blanking symbol or reset. It never leaves the range ±8.
- R8: With `de_i` low, `ctrl_i` = 00, 01, 10, 11 produce 1101010100, 0010101011, 0101010100, 1010101011 respectively (written MSB first).
- R9: A blanking symbol clears the running balance, so the next active symbol follows the R5 rule.
- R10: Every blanking symbol has at least seven transitions between adjacent bits.
- R11: `data_i` has no effect while `de_i` is low, and `ctrl_i` has no effect while `de_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_i | input | 1 | High for active pixels, low for blanking |
| data_i | input | 8 | Colour component value |
| ctrl_i | input | 2 | Blanking control pair, bit 0 = C0, bit 1 = C1 |
| sym_o | output | 10 | Registered line symbol |

## Verification
Four kinds of active input are used. An ascending sweep of all 256 bytes covers every branch of the chaining rule, including the four-ones tie that depends on bit 0. A pseudo-random byte stream moves the running balance through both signs, so the inversion rule is tried away from zero. Long runs of extreme and alternating bytes (all zeros, all ones, 0x55/0xAA, nibble patterns) push the balance to its limits. Blanking symbols are inserted between active runs, and a reset is applied in the middle of a run, which shows whether the balance restarts at zero.

// File: rtl/tmds_enc_pkg.sv
`timescale 1ns/1ps
package tmds_enc_pkg;

   // Chaining operator chosen by the first stage; the value is the symbol bit.
   typedef enum logic {
      CHAIN_XNOR = 1'b0,
      CHAIN_XOR  = 1'b1
   } chain_e;

   // Blanking selector, C1 in bit 1 and C0 in bit 0.
   typedef enum logic [1:0] {
      BLANK_C00 = 2'b00,
      BLANK_C01 = 2'b01,
      BLANK_C10 = 2'b10,
      BLANK_C11 = 2'b11
   } blank_sel_e;

   // Balance counter width: holds +/-2*DW so that intermediate terms fit.
   function automatic int balance_width(input int dw);
      return $clog2(dw) + 2;
   endfunction

endpackage

// File: rtl/tmds_popcount.sv
`timescale 1ns/1ps
module tmds_popcount #(
   parameter int W    = 8,
   parameter bit TREE = 1'b1,
   localparam int CW  = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   if (W < 1) begin : g_bad_w
      $error("tmds_popcount: W must be at least 1");
   end

   if (TREE && W >= 4) begin : g_tree
      localparam int LW  = W / 2;
      localparam int HW  = W - LW;
      localparam int LCW = $clog2(LW + 1);
      localparam int HCW = $clog2(HW + 1);

      logic [LCW-1:0] lo_cnt;
      logic [HCW-1:0] hi_cnt;

      tmds_popcount #(.W(LW), .TREE(1'b1)) u_lo (
         .vec_i (vec_i[LW-1:0]),
         .cnt_o (lo_cnt)
      );
      tmds_popcount #(.W(HW), .TREE(1'b1)) u_hi (
         .vec_i (vec_i[W-1:LW]),
         .cnt_o (hi_cnt)
      );

      assign cnt_o = CW'(lo_cnt) + CW'(hi_cnt);
   end else begin : g_flat
      always_comb begin
         cnt_o = '0;
         for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
         end
      end
   end

endmodule

// File: rtl/tmds_chain_stage.sv
`timescale 1ns/1ps
module tmds_chain_stage
   import tmds_enc_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit POP_TREE = 1'b1
) (
   input  logic [DW-1:0] data_i,
   output logic [DW:0]   word_o
);

   localparam int CW   = $clog2(DW + 1);
   localparam int HALF = DW / 2;

   logic [CW-1:0] ones;
   chain_e        mode;
   logic [DW-1:0] chain;

   tmds_popcount #(.W(DW), .TREE(POP_TREE)) u_ones (
      .vec_i (data_i),
      .cnt_o (ones)
   );

   // Heavy bytes (or ties with a clear LSB) take XNOR chaining.
   always_comb begin
      if (ones > CW'(HALF) || (ones == CW'(HALF) && !data_i[0])) begin
         mode = CHAIN_XNOR;
      end else begin
         mode = CHAIN_XOR;
      end
   end

   always_comb begin
      chain[0] = data_i[0];
      for (int i = 1; i < DW; i++) begin
         if (mode == CHAIN_XNOR) begin
            chain[i] = ~(chain[i-1] ^ data_i[i]);
         end else begin
            chain[i] = chain[i-1] ^ data_i[i];
         end
      end
   end

   assign word_o = {logic'(mode), chain};

endmodule

// File: rtl/tmds_balance_stage.sv
`timescale 1ns/1ps
module tmds_balance_stage #(
   parameter int DW       = 8,
   parameter int CNT_W    = 5,
   parameter bit POP_TREE = 1'b1,
   localparam int SW      = DW + 2
) (
   input  logic [DW:0]              word_i,
   input  logic signed [CNT_W-1:0]  bal_i,
   output logic [SW-1:0]            sym_o,
   output logic signed [CNT_W-1:0]  bal_next_o
);

   localparam int CW = $clog2(DW + 1);
   localparam logic signed [CNT_W-1:0] TWO = CNT_W'(2);

   if (CNT_W < CW + 1) begin : g_bad_cnt
      $error("tmds_balance_stage: CNT_W too narrow for DW");
   end

   logic [CW-1:0]           ones;
   logic signed [CNT_W-1:0] excess;
   logic signed [CNT_W-1:0] delta;
   logic                    xor_mode;
   logic                    invert;

   tmds_popcount #(.W(DW), .TREE(POP_TREE)) u_ones (
      .vec_i (word_i[DW-1:0]),
      .cnt_o (ones)
   );

   // ones - zeros of the chained word; modular arithmetic at CNT_W bits.
   assign excess   = $signed(CNT_W'({ones, 1'b0}) - CNT_W'(DW));
   assign xor_mode = word_i[DW];

   always_comb begin
      if (bal_i == '0 || excess == '0) begin
         invert = ~xor_mode;
         delta  = xor_mode ? excess : -excess;
      end else if (bal_i[CNT_W-1] == excess[CNT_W-1]) begin
         invert = 1'b1;
         delta  = (xor_mode ? TWO : '0) - excess;
      end else begin
         invert = 1'b0;
         delta  = excess - (xor_mode ? '0 : TWO);
      end
   end

   assign sym_o      = {invert, xor_mode,
                        invert ? ~word_i[DW-1:0] : word_i[DW-1:0]};
   assign bal_next_o = bal_i + delta;

endmodule

// File: rtl/tmds_ctrl_table.sv
`timescale 1ns/1ps
module tmds_ctrl_table
   import tmds_enc_pkg::*;
#(
   parameter int DW  = 8,
   localparam int SW = DW + 2
) (
   input  logic [1:0]    sel_i,
   output logic [SW-1:0] code_o,
   output logic [SW-1:0] idle_o
);

   logic [DW-1:0] base;
   logic [SW-1:0] pat_a;
   logic [SW-1:0] pat_b;

   // Alternating tail with the two lowest bits held low.
   for (genvar i = 0; i < DW; i++) begin : g_base
      if (i >= 2 && (i % 2) == 0) begin : g_one
         assign base[i] = 1'b1;
      end else begin : g_zero
         assign base[i] = 1'b0;
      end
   end

   assign pat_a = {2'b11, base};
   assign pat_b = {2'b01, base};

   always_comb begin
      unique case (blank_sel_e'(sel_i))
         BLANK_C00: code_o = pat_a;
         BLANK_C01: code_o = ~pat_a;
         BLANK_C10: code_o = pat_b;
         BLANK_C11: code_o = ~pat_b;
      endcase
   end

   assign idle_o = pat_a;

endmodule

// File: rtl/tmds_lane_encoder.sv
`timescale 1ns/1ps
module tmds_lane_encoder
   import tmds_enc_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit POP_TREE = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          de_i,
   input  logic [DW-1:0] data_i,
   input  logic [1:0]    ctrl_i,
   output logic [DW+1:0] sym_o
);

   localparam int SW        = DW + 2;
   localparam int CNT_W     = balance_width(DW);
   localparam int MIN_TRANS = DW - 1;

   if (DW < 4 || (DW % 2) != 0) begin : g_bad_dw
      $error("tmds_lane_encoder: DW must be even and at least 4");
   end

   logic [DW:0]             word;
   logic [SW-1:0]           data_sym;
   logic [SW-1:0]           ctrl_sym;
   logic [SW-1:0]           idle_sym;
   logic [SW-1:0]           sym_q;
   logic signed [CNT_W-1:0] bal_q;
   logic signed [CNT_W-1:0] bal_next;

   tmds_chain_stage #(.DW(DW), .POP_TREE(POP_TREE)) u_chain (
      .data_i (data_i),
      .word_o (word)
   );

   tmds_balance_stage #(.DW(DW), .CNT_W(CNT_W), .POP_TREE(POP_TREE)) u_balance (
      .word_i     (word),
      .bal_i      (bal_q),
      .sym_o      (data_sym),
      .bal_next_o (bal_next)
   );

   tmds_ctrl_table #(.DW(DW)) u_ctrl (
      .sel_i  (ctrl_i),
      .code_o (ctrl_sym),
      .idle_o (idle_sym)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sym_q <= idle_sym;
         bal_q <= '0;
      end else if (de_i) begin
         sym_q <= data_sym;
         bal_q <= bal_next;
      end else begin
         sym_q <= ctrl_sym;
         bal_q <= '0;
      end
   end

   assign sym_o = sym_q;

   // R2: recovered bit 0 follows the sampled data bit 0
   p_bit0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(de_i)) |-> ((sym_o[0] ^ sym_o[SW-1]) == $past(data_i[0])));

   // R4: chaining flag follows the ones count of the sampled byte
   p_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(de_i)) |->
         (sym_o[DW] == !(($countones($past(data_i)) > DW/2) ||
                         ($countones($past(data_i)) == DW/2 && !$past(data_i[0])))));

   // R7: running balance stays inside +/-DW
   p_bal_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(bal_q) <= DW) && (int'(bal_q) >= -DW));

   // R8: blanking symbol bit 0 carries C0, top bit is the XNOR of C0 and C1
   p_ctrl_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(de_i)) |->
         ((sym_o[0] == $past(ctrl_i[0])) &&
          (sym_o[SW-1] == !($past(ctrl_i[0]) ^ $past(ctrl_i[1])))));

   // R9: a blanking cycle leaves the balance at zero
   p_bal_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !de_i |=> (bal_q == '0));

   // R10: blanking symbols are rich in transitions
   p_ctrl_trans_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(de_i)) |->
         ($countones(sym_o[SW-1:1] ^ sym_o[SW-2:0]) >= MIN_TRANS));

endmodule

// File: tb/tb_tmds_lane_encoder.sv
`timescale 1ns/1ps
module tb_tmds_lane_encoder;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       de    = 1'b0;
   logic [1:0] ctrl  = 2'b00;
   logic [7:0] data  = 8'h00;
   logic [9:0] sym;

   int checks     = 0;
   int errors     = 0;
   int m_bal      = 0;
   int run_disp   = 0;
   bit after_ctrl = 1'b1;
   bit done       = 1'b0;

   always #10 clk = ~clk;

   tmds_lane_encoder dut (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .de_i   (de),
      .data_i (data),
      .ctrl_i (ctrl),
      .sym_o  (sym)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] ctrl_ref(input logic [1:0] c);
      case (c)
         2'b00:   return 10'b1101010100;
         2'b01:   return 10'b0010101011;
         2'b10:   return 10'b0101010100;
         default: return 10'b1010101011;
      endcase
   endfunction

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic step(input logic de_v, input logic [1:0] c_v, input logic [7:0] d_v);
      logic [9:0] exp;
      logic [9:0] prev;
      logic [7:0] qm;
      logic [7:0] dec;
      logic       q8;
      logic       inv;
      int         n1;
      int         e;
      bit         rule_zero;
      prev = sym;
      de   = de_v;
      ctrl = c_v;
      data = d_v;
      qm = '0; q8 = 1'b0; inv = 1'b0; rule_zero = 1'b0;
      if (de_v) begin
         n1    = $countones(d_v);
         q8    = !((n1 > 4) || (n1 == 4 && !d_v[0]));
         qm[0] = d_v[0];
         for (int i = 1; i < 8; i++) begin
            qm[i] = q8 ? (qm[i-1] ^ d_v[i]) : !(qm[i-1] ^ d_v[i]);
         end
         e         = 2 * $countones(qm) - 8;
         rule_zero = (m_bal == 0) || (e == 0);
         inv       = rule_zero ? !q8 : ((m_bal > 0) == (e > 0));
         exp       = {inv, q8, inv ? ~qm : qm};
         m_bal     = m_bal + 2 * $countones(exp) - 10;
      end else begin
         exp   = ctrl_ref(c_v);
         m_bal = 0;
      end
      #1;
      chk(sym === prev, "R1 output changed before the clock edge", int'(sym), int'(prev));
      @(negedge clk);
      if (de_v) begin
         dec = sym[7:0] ^ {8{sym[9]}};
         chk(dec[0] == d_v[0], "R2 recovered bit 0", int'(dec[0]), int'(d_v[0]));
         chk(dec == qm, "R3 recovered chained word", int'(dec), int'(qm));
         chk(sym[8] == q8, "R4 chaining flag", int'(sym[8]), int'(q8));
         if (rule_zero) begin
            chk(sym[9] == inv, "R5 inversion at zero balance or balanced word", int'(sym[9]), int'(inv));
         end else begin
            chk(sym[9] == inv, "R6 inversion by sign match", int'(sym[9]), int'(inv));
         end
         if (after_ctrl) begin
            chk(sym[9] == !sym[8], "R9 first symbol after blanking or reset", int'(sym[9]), int'(!sym[8]));
         end
         run_disp = run_disp + 2 * $countones(sym) - 10;
         chk(run_disp == m_bal && run_disp <= 8 && run_disp >= -8,
             "R7 running balance", run_disp, m_bal);
         if (c_v != 2'b00) begin
            chk(sym === exp, "R11 control pair ignored while active", int'(sym), int'(exp));
         end else begin
            chk(sym === exp, "R5 full active symbol", int'(sym), int'(exp));
         end
         after_ctrl = 1'b0;
      end else begin
         chk(sym === exp, "R8 blanking code", int'(sym), int'(exp));
         chk($countones(sym[9:1] ^ sym[8:0]) >= 7, "R10 blanking transitions",
             $countones(sym[9:1] ^ sym[8:0]), 7);
         if (d_v != 8'h00) begin
            chk(sym === exp, "R11 data ignored while blanking", int'(sym), int'(exp));
         end
         run_disp   = 0;
         after_ctrl = 1'b1;
      end
   endtask

   initial begin
      logic [7:0] lfsr;
      logic [7:0] pats [10];
      pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h01, 8'hFE, 8'h80, 8'h7F};

      repeat (3) @(negedge clk);
      chk(sym === 10'b1101010100, "R1 symbol during reset", int'(sym), int'(10'b1101010100));
      rst_n = 1'b1;
      @(negedge clk);

      // all blanking codes with assorted data on the data input
      for (int i = 0; i < 16; i++) step(1'b0, 2'(i), 8'(i * 37));

      // ascending sweep of every byte, control pair rotating
      for (int i = 0; i < 256; i++) step(1'b1, 2'(i), 8'(i));

      // descending sweep broken by blanking every 16 symbols
      for (int i = 0; i < 256; i++) begin
         if (i % 16 == 0) step(1'b0, 2'(i / 16), 8'hA5);
         step(1'b1, 2'b00, 8'(255 - i));
      end

      // pseudo-random stream
      lfsr = 8'h01;
      for (int i = 0; i < 600; i++) begin
         step(1'b1, 2'b00, lfsr);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end

      // long runs of extreme and alternating bytes
      for (int p = 0; p < 10; p++) begin
         for (int k = 0; k < 8; k++) step(1'b1, 2'b00, pats[p]);
         for (int k = 0; k < 4; k++) step(1'b1, 2'b00, pats[(p + 1) % 10]);
      end

      // reset in the middle of an active run clears the balance
      step(1'b1, 2'b00, 8'hFF);
      step(1'b1, 2'b00, 8'h10);
      rst_n = 1'b0;
      #1;
      chk(sym === 10'b1101010100, "R1 asynchronous reset symbol", int'(sym), int'(10'b1101010100));
      @(negedge clk);
      rst_n      = 1'b1;
      m_bal      = 0;
      run_disp   = 0;
      after_ctrl = 1'b1;
      for (int k = 0; k < 6; k++) step(1'b1, 2'b00, 8'h10);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule